// File: doc/BRIEF.md
# Instruction Queue Reconstruction Tracker

This block watches the external bus of a 16-bit CPU that prefetches code into a small internal queue, and rebuilds that queue outside the CPU so that a debugger can tell which opcode starts and when. The CPU drives a 2-bit queue status whose meaning alternates with the bus E clock. Sampled when E rises, it says how the queue moves. Sampled when E falls, it says whether an instruction or an interrupt sequence starts.

The tracker samples E, the status pins, the address bus, the data bus and the read/write strobe in a faster system clock domain. It holds a bus buffer, a holding latch and two queue stages. Each of these storage elements keeps a data word, the address it was fetched from, and a valid flag. For every execution start it raises a one-cycle pulse with the opcode byte, the opcode address and the kind of start. Interrupt starts and starts on an empty second stage have their own pulse outputs.

Top module: `iq_tracker`

## Requirements
- R1: After reset, start_pulse, irq_pulse and err_pulse are low and every storage element is empty. An instruction start that arrives before any queue load raises err_pulse.
- R2: A movement code of 01 seen at a rising E edge copies the bus buffer into the holding latch. The latch contents reach stage 1 at a later 11 advance.
- R3: A movement code of 10 seen at a rising E edge moves stage 1 into stage 2 and loads stage 1 from the bus buffer.
- R4: A movement code of 11 seen at a rising E edge moves stage 1 into stage 2, loads stage 1 from the holding latch, and empties the latch. A second 11 before the latch is refilled therefore loads an empty entry.
- R5: A movement uses the address, data and strobe captured at the preceding falling E edge. It ignores whatever is on the bus when E rises.
- R6: A start code of 10 seen at a falling E edge (even start) reports the high byte of stage 2 as the opcode, the stage 2 address as the opcode address, and start_kind 10.
- R7: A start code of 11 seen at a falling E edge (odd start) reports the low byte of stage 2 as the opcode, the stage 2 address plus one as the opcode address, and start_kind 11.
- R8: A start code of 01 seen at a falling E edge raises irq_pulse with start_kind 01, and start_pulse stays low.
- R9: An even or odd start while stage 2 is empty raises err_pulse instead of start_pulse.
- R10: A word captured while bus_rw is 0 (a write) is stored as an empty entry. Executing from it raises err_pulse.
- R11: Each event output is a pulse one system clock long. It rises on the third system clock edge after the E edge appears on the pins, and start_kind, start_op and start_addr are valid while it is high.
- R12: A movement code of 00 leaves the latch and both stages unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than E |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_e | input | 1 | Bus E clock from the CPU |
| q_stat | input | 2 | Time-multiplexed queue status |
| bus_addr | input | 16 | CPU address bus |
| bus_data | input | 16 | CPU data bus |
| bus_rw | input | 1 | 1 for a read cycle, 0 for a write |
| start_pulse | output | 1 | An opcode starts executing |
| start_kind | output | 2 | 01 interrupt, 10 even, 11 odd |
| start_op | output | 8 | Opcode byte of the start |
| start_addr | output | 16 | Address of the opcode byte |
| irq_pulse | output | 1 | An interrupt sequence starts |
| err_pulse | output | 1 | A start found stage 2 empty |

## Verification
Every event pulse is due exactly three system clock edges after the E edge that causes it is driven on the pins: two synchronizer flops and one output register. Stimulus changes at a falling system clock edge. The bench then compares all outputs against its own behavioural queue model at every following falling edge. It expects a pulse only at the third of these comparisons and silence at all the others. Bus contents change between each falling and rising E edge, so a movement that read the live bus would deliver a wrong opcode at a later start.

// File: rtl/iqt_pkg.sv
package iqt_pkg;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int OPW = 8;

    typedef enum logic [1:0] {
        MV_NONE     = 2'b00,
        MV_LATCH    = 2'b01,
        MV_ADV_BUS  = 2'b10,
        MV_ADV_HOLD = 2'b11
    } mv_e;

    typedef enum logic [1:0] {
        ST_NONE = 2'b00,
        ST_IRQ  = 2'b01,
        ST_EVEN = 2'b10,
        ST_ODD  = 2'b11
    } st_e;

    typedef struct packed {
        logic          v;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } word_t;
endpackage

// File: rtl/iqt_sync.sv
module iqt_sync
    import iqt_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          e_pin,
    input  logic [1:0]    stat_pin,
    input  logic [AW-1:0] addr_pin,
    input  logic [DW-1:0] data_pin,
    input  logic          rw_pin,
    output logic          e_rise,
    output logic          e_fall,
    output logic [1:0]    stat,
    output word_t         bus
);
    typedef struct packed {
        logic          e;
        logic [1:0]    st;
        logic          rw;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } smp_t;

    typedef struct packed {
        smp_t [SYNC_N-1:0] chain;
        logic              e_last;
    } sync_s;

    sync_s s_d, s_q;
    smp_t  tail;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = '{e: e_pin, st: stat_pin, rw: rw_pin, a: addr_pin, d: data_pin};
        for (int i = 1; i < SYNC_N; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
        s_d.e_last = s_q.chain[SYNC_N-1].e;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tail   = s_q.chain[SYNC_N-1];
    assign e_rise = tail.e & ~s_q.e_last;
    assign e_fall = ~tail.e & s_q.e_last;
    assign stat   = tail.st;
    assign bus    = '{v: tail.rw, addr: tail.a, data: tail.d};
endmodule

// File: rtl/iqt_queue.sv
module iqt_queue
    import iqt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       e_rise,
    input  logic       e_fall,
    input  logic [1:0] stat,
    input  word_t      bus,
    output word_t      stage2
);
    typedef struct packed {
        word_t bbuf;
        word_t hold;
        word_t st1;
        word_t st2;
    } q_s;

    q_s  q_d, q_q;
    mv_e mv;

    assign mv = mv_e'(stat);

    always_comb begin
        q_d = q_q;
        if (e_fall) begin
            q_d.bbuf = bus;
        end
        if (e_rise) begin
            unique case (mv)
                MV_LATCH: q_d.hold = q_q.bbuf;
                MV_ADV_BUS: begin
                    q_d.st2 = q_q.st1;
                    q_d.st1 = q_q.bbuf;
                end
                MV_ADV_HOLD: begin
                    q_d.st2    = q_q.st1;
                    q_d.st1    = q_q.hold;
                    q_d.hold.v = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign stage2 = q_q.st2;

    p_adv_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (e_rise && mv == MV_ADV_BUS) |=> (q_q.st2 == $past(q_q.st1) && q_q.st1 == $past(q_q.bbuf)));

    p_hold_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (e_rise && mv == MV_ADV_HOLD) |=> !q_q.hold.v);

    p_latch_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (e_rise && mv == MV_LATCH) |=> q_q.hold == $past(q_q.bbuf));

    p_no_move_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (e_rise && mv == MV_NONE) |=> ($stable(q_q.hold) && $stable(q_q.st1) && $stable(q_q.st2)));
endmodule

// File: rtl/iqt_start.sv
module iqt_start
    import iqt_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           e_fall,
    input  logic [1:0]     stat,
    input  word_t          stage2,
    output logic           start_pulse,
    output logic           irq_pulse,
    output logic           err_pulse,
    output logic [1:0]     kind,
    output logic [OPW-1:0] op,
    output logic [AW-1:0]  op_addr
);
    typedef struct packed {
        logic           pulse;
        logic           irq;
        logic           err;
        st_e            kind;
        logic [OPW-1:0] op;
        logic [AW-1:0]  addr;
    } ev_s;

    ev_s e_d, e_q;
    st_e sk;

    assign sk = st_e'(stat);

    always_comb begin
        e_d       = e_q;
        e_d.pulse = 1'b0;
        e_d.irq   = 1'b0;
        e_d.err   = 1'b0;
        if (e_fall) begin
            unique case (sk)
                ST_IRQ: begin
                    e_d.irq  = 1'b1;
                    e_d.kind = ST_IRQ;
                end
                ST_EVEN, ST_ODD: begin
                    e_d.kind = sk;
                    if (!stage2.v) begin
                        e_d.err = 1'b1;
                    end else begin
                        e_d.pulse = 1'b1;
                        e_d.op    = (sk == ST_EVEN) ? stage2.data[DW-1 -: OPW]
                                                    : stage2.data[OPW-1:0];
                        e_d.addr  = stage2.addr + ((sk == ST_ODD) ? AW'(1) : AW'(0));
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign start_pulse = e_q.pulse;
    assign irq_pulse   = e_q.irq;
    assign err_pulse   = e_q.err;
    assign kind        = e_q.kind;
    assign op          = e_q.op;
    assign op_addr     = e_q.addr;

    p_err_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> !$past(stage2.v));

    p_odd_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse && kind == ST_ODD) |-> op_addr == $past(stage2.addr) + AW'(1));

    p_irq_alone_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (!start_pulse && !err_pulse && kind == ST_IRQ));

    p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse || err_pulse || irq_pulse) |=> !(start_pulse || err_pulse || irq_pulse));
endmodule

// File: rtl/iq_tracker.sv
module iq_tracker
    import iqt_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_e,
    input  logic [1:0]     q_stat,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_data,
    input  logic           bus_rw,
    output logic           start_pulse,
    output logic [1:0]     start_kind,
    output logic [OPW-1:0] start_op,
    output logic [AW-1:0]  start_addr,
    output logic           irq_pulse,
    output logic           err_pulse
);
    logic       e_rise, e_fall;
    logic [1:0] stat;
    word_t      bus_w, stage2;

    iqt_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .e_pin    (bus_e),
        .stat_pin (q_stat),
        .addr_pin (bus_addr),
        .data_pin (bus_data),
        .rw_pin   (bus_rw),
        .e_rise   (e_rise),
        .e_fall   (e_fall),
        .stat     (stat),
        .bus      (bus_w)
    );

    iqt_queue u_queue (
        .clk    (clk),
        .rst_n  (rst_n),
        .e_rise (e_rise),
        .e_fall (e_fall),
        .stat   (stat),
        .bus    (bus_w),
        .stage2 (stage2)
    );

    iqt_start u_start (
        .clk         (clk),
        .rst_n       (rst_n),
        .e_fall      (e_fall),
        .stat        (stat),
        .stage2      (stage2),
        .start_pulse (start_pulse),
        .irq_pulse   (irq_pulse),
        .err_pulse   (err_pulse),
        .kind        (start_kind),
        .op          (start_op),
        .op_addr     (start_addr)
    );

    p_one_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_pulse, irq_pulse, err_pulse}));
endmodule

// File: tb/iq_tracker_bench.sv
module iq_tracker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_e = 1'b0;
    logic [1:0]  q_stat = 2'b00;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_data = '0;
    logic        bus_rw = 1'b1;
    logic        start_pulse, irq_pulse, err_pulse;
    logic [1:0]  start_kind;
    logic [7:0]  start_op;
    logic [15:0] start_addr;

    int checks = 0;
    int failures = 0;

    // behavioural model of the queue
    logic        mbv = 0, mhv = 0, m1v = 0, m2v = 0;
    logic [15:0] mba = 0, mbd = 0, mha = 0, mhd = 0, m1a = 0, m1d = 0, m2a = 0, m2d = 0;
    logic        e_prev = 0;

    always #10 clk = ~clk;

    iq_tracker u_iq_tracker (
        .clk (clk), .rst_n (rst_n), .bus_e (bus_e), .q_stat (q_stat),
        .bus_addr (bus_addr), .bus_data (bus_data), .bus_rw (bus_rw),
        .start_pulse (start_pulse), .start_kind (start_kind), .start_op (start_op),
        .start_addr (start_addr), .irq_pulse (irq_pulse), .err_pulse (err_pulse)
    );

    task automatic chk(input logic ok, input string rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // one E half-period: inputs change at a falling clk edge, then 8 clocks are compared
    task automatic phase(input logic ev, input logic [1:0] st, input logic [15:0] a,
                         input logic [15:0] d, input logic rw, input string note);
        logic xs = 0, xi = 0, xe = 0;
        logic [1:0] xk = 0;
        logic [7:0] xo = 0;
        logic [15:0] xa = 0;
        string tag = "R11";
        bus_e = ev; q_stat = st; bus_addr = a; bus_data = d; bus_rw = rw;
        if (!ev && e_prev) begin
            mbv = rw; mba = a; mbd = d;
            if (st == 2'b01) begin
                xi = 1; xk = 2'b01; tag = "R8";
            end else if (st[1]) begin
                if (!m2v) begin
                    xe = 1; tag = "R9";
                end else begin
                    xs = 1; xk = st;
                    xo = (st == 2'b10) ? m2d[15:8] : m2d[7:0];
                    xa = m2a + ((st == 2'b11) ? 16'd1 : 16'd0);
                    tag = (st == 2'b10) ? "R6" : "R7";
                end
            end
        end else if (ev && !e_prev) begin
            case (st)
                2'b01: begin mhv = mbv; mha = mba; mhd = mbd; end
                2'b10: begin m2v = m1v; m2a = m1a; m2d = m1d; m1v = mbv; m1a = mba; m1d = mbd; end
                2'b11: begin m2v = m1v; m2a = m1a; m2d = m1d; m1v = mhv; m1a = mha; m1d = mhd; mhv = 0; end
                default: ;
            endcase
        end
        e_prev = ev;
        if (note != "") tag = {tag, "/", note};
        for (int i = 1; i <= 8; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk(start_pulse == (i == 3 && xs), tag, "start_pulse", start_pulse, (i == 3 && xs));
            chk(irq_pulse == (i == 3 && xi), tag, "irq_pulse", irq_pulse, (i == 3 && xi));
            chk(err_pulse == (i == 3 && xe), tag, "err_pulse", err_pulse, (i == 3 && xe));
            if (i == 3 && (xs || xi)) chk(start_kind == xk, tag, "start_kind", start_kind, xk);
            if (i == 3 && xs) begin
                chk(start_op == xo, tag, "start_op", start_op, xo);
                chk(start_addr == xa, tag, "start_addr", start_addr, xa);
            end
        end
    endtask

    // one bus cycle: fall with a start code, then rise with a movement code; the bus changes at the rise (R5)
    task automatic cyc(input logic [1:0] st, input logic [1:0] mv, input logic [15:0] a,
                       input logic [15:0] d, input logic rw, input string note);
        phase(1'b0, st, a, d, rw, note);
        phase(1'b1, mv, ~a, ~d, ~rw, note);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R11 watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!start_pulse && !irq_pulse && !err_pulse, "R1", "outputs in reset", 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!start_pulse && !irq_pulse && !err_pulse, "R1", "outputs after reset", 0, 0);
        phase(1'b1, 2'b00, 16'h0, 16'h0, 1'b1, "R1");
        // start on empty queue (R1, R9)
        cyc(2'b10, 2'b00, 16'h0100, 16'h1111, 1'b1, "R1");
        // fill two stages (R3, R5)
        cyc(2'b00, 2'b10, 16'h1000, 16'hA1B2, 1'b1, "R3");
        cyc(2'b00, 2'b10, 16'h1002, 16'hC3D4, 1'b1, "R5");
        // even start, no movement (R6, R12)
        cyc(2'b10, 2'b00, 16'h1004, 16'hE5F6, 1'b1, "R12");
        cyc(2'b10, 2'b00, 16'h1004, 16'hE5F6, 1'b1, "R12");
        // odd start, latch the word (R7, R2)
        cyc(2'b11, 2'b01, 16'h1004, 16'hE5F6, 1'b1, "R2");
        // interrupt, advance from latch (R8, R4)
        cyc(2'b01, 2'b11, 16'h2000, 16'h0000, 1'b1, "R4");
        cyc(2'b10, 2'b00, 16'h2002, 16'h0000, 1'b1, "R4");
        // latch now empty: second 11 advance loads an empty entry (R4)
        cyc(2'b11, 2'b11, 16'h2004, 16'h0000, 1'b1, "R4");
        cyc(2'b00, 2'b10, 16'h2006, 16'h0000, 1'b1, "R4");
        cyc(2'b10, 2'b00, 16'h2008, 16'h0000, 1'b1, "R4");
        // write cycles stored empty (R10)
        cyc(2'b00, 2'b10, 16'h3000, 16'h5A5A, 1'b0, "R10");
        cyc(2'b00, 2'b10, 16'h3002, 16'h6B6B, 1'b0, "R10");
        cyc(2'b11, 2'b00, 16'h3004, 16'h7C7C, 1'b1, "R10");
        // mixed patterns
        for (int k = 0; k < 60; k++) begin
            logic [15:0] a = 16'h4000 + 16'(k * 2);
            logic [15:0] d = 16'(k * 16'h3B7 + 16'h1234);
            cyc(2'((k * 3) % 4), 2'((k * 7 + 2) % 4), a, d, (k % 9) != 4, "");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule